// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Interrupt and Frequency-Test Output

This block watches the running time of a real-time clock (seconds, minutes, hours and day of month, all in BCD) and compares it against four alarm setting registers. A single pulse on `secTick` marks the cycle in which the time inputs hold a new second. Each alarm register keeps its compare value in the low bits and a mask bit in bit 7. The four mask bits together choose how often the alarm repeats. A match sets a sticky alarm flag and latches an interrupt request. The interrupt drives a shared active-low, open-drain pin when the alarm enable is set. While the system runs on its backup supply, the pin is driven only if the backup-alarm enable is also set.

The same pin can carry a frequency-test square wave. The wave is built by dividing a 32.768 kHz clock enable by `DIV_RATIO` (64 by default), which gives 512 Hz. The software side touches the block through a small write port and a flags-access strobe. A flags access releases the interrupt at once, while the flag itself clears only when the access ends. The fall of `powerFail` marks the return of main power, and it clears the enables and the test-mode bit.

Top module: `rtc_alarm_irq`

## Requirements
- R1: With mask bits {date,hour,min,sec} (bit 7 of addresses 3,2,1,0) equal to 1111, or any combination other than 1110, 1100, 1000 and 0000, every `secTick` pulse is an alarm match.
- R2: Mask 1110: a `secTick` pulse matches only if `curSec` equals bits 6:0 of the seconds alarm (address 0).
- R3: Mask 1100: a match needs the seconds to be equal and `curMin` to equal bits 6:0 of address 1.
- R4: Mask 1000: a match also needs `curHour` to equal bits 5:0 of address 2.
- R5: Mask 0000: a match also needs `curDate` to equal bits 5:0 of address 3.
- R6: `alarmFlag` reads 1 in the cycle after a matching `secTick` cycle. It is set only by `secTick` pulses, so time inputs that stay matching without a pulse never set it again.
- R7: `pinDriveLow` is 1 while an interrupt is latched and the alarm enable (address 4, bit 7) is 1. With the enable at 0 the flag still sets but the pin stays released.
- R8: A cycle with `flagsAcc` high releases the latched interrupt from the next cycle on. `alarmFlag` stays set through the access and clears in the cycle after the first cycle with `flagsAcc` low. A new match takes priority over both clears.
- R9: While `powerFail` is 1, the alarm drives the pin only if the backup enable (address 4, bit 6) is also 1, and writes through the register port are ignored.
- R10: In the cycle after `powerFail` falls, the alarm enable, the backup enable and the test bit are 0. A match in that same cycle still sets `alarmFlag`.
- R11: When the test bit (address 4, bit 5) is 1, the alarm enable is 0 and `wdSteer` or `wdZero` is 1, the pin starts released and toggles once every `DIV_RATIO`/2 `tick32k` pulses. Otherwise no wave is produced.
- R12: `pinLevel` is always the inverse of `pinDriveLow`, and after reset `alarmFlag` is 0 and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on) |
| tick32k | input | 1 | One-cycle enable at 32.768 kHz |
| secTick | input | 1 | One-cycle pulse when the time inputs show a new second |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 6 | Current hours, BCD, 24-hour |
| curDate | input | 6 | Current day of month, BCD |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0..3 alarm fields, 4 enables |
| wrData | input | 8 | Write data |
| flagsAcc | input | 1 | High during a read or write of the flags register |
| powerFail | input | 1 | High while running from the backup supply |
| wdSteer | input | 1 | Watchdog steering bit |
| wdZero | input | 1 | High when the watchdog register is zero |
| alarmFlag | output | 1 | Sticky alarm flag |
| pinDriveLow | output | 1 | Open-drain drive-low enable of the shared pin |
| pinLevel | output | 1 | Pin level, high when not driven |

## Verification
The assertions assume that `secTick` and `tick32k` are single-cycle pulses, and that the time inputs are stable in the cycle of a `secTick` pulse. The bench therefore changes time values only between pulses and raises each strobe for exactly one clock. The assertions also assume that `flagsAcc` is a level held for the whole access. The bench drives each access as a level lasting a few cycles. A behavioural model checks the flag and the pin on every clock. It covers every mask rate, matches during backup and at power-up, and the test wave with each steering choice.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int NUM_ALM  = 4;
  localparam int FIELD_W  = 7;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int MASK_BIT = REG_W - 1;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 3'd4;

  // control bits at the enables address
  localparam int CFG_AE  = 7;
  localparam int CFG_ABE = 6;
  localparam int CFG_FT  = 5;

  typedef enum logic [2:0] {
    RATE_EVERY,
    RATE_SEC,
    RATE_MINSEC,
    RATE_HMS,
    RATE_FULL
  } rate_e;

  typedef struct packed {
    logic [NUM_ALM-1:0] almWr;
    logic               divRun;
  } ctrlStrobes_t;

  // field widths: seconds, minutes, hours, date
  function automatic int fieldWidth(input int idx);
    case (idx)
      0, 1:    return 7;
      default: return 6;
    endcase
  endfunction

  // maskBits ordered {date,hour,min,sec}
  function automatic rate_e decodeRate(input logic [NUM_ALM-1:0] maskBits);
    case (maskBits)
      4'b1110: return RATE_SEC;
      4'b1100: return RATE_MINSEC;
      4'b1000: return RATE_HMS;
      4'b0000: return RATE_FULL;
      default: return RATE_EVERY;
    endcase
  endfunction

  function automatic logic [NUM_ALM-1:0] rateNeeds(input rate_e rate);
    case (rate)
      RATE_SEC:    return 4'b0001;
      RATE_MINSEC: return 4'b0011;
      RATE_HMS:    return 4'b0111;
      RATE_FULL:   return 4'b1111;
      default:     return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int DIV_RATIO = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [REG_W-1:0]   wrData,
  input  logic               secTick,
  input  logic               tick32k,
  input  logic [6:0]         curSec,
  input  logic [6:0]         curMin,
  input  logic [5:0]         curHour,
  input  logic [5:0]         curDate,
  output logic               matchHit,
  output logic               ftWave
);

  localparam int HALF  = DIV_RATIO / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [REG_W-1:0]   almReg   [NUM_ALM];
  logic [FIELD_W-1:0] curField [NUM_ALM];
  logic [NUM_ALM-1:0] fieldEq;
  logic [NUM_ALM-1:0] maskBits;
  logic [NUM_ALM-1:0] needField;
  rate_e              rate;

  assign curField[0] = curSec;
  assign curField[1] = curMin;
  assign curField[2] = {1'b0, curHour};
  assign curField[3] = {1'b0, curDate};

  // alarm registers and per-field comparators
  for (genvar i = 0; i < NUM_ALM; i++) begin : gAlm
    localparam int W = fieldWidth(i);
    localparam logic [FIELD_W-1:0] FMASK = FIELD_W'((1 << W) - 1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  almReg[i] <= '0;
      else if (strobes.almWr[i])  almReg[i] <= wrData;
    end

    assign fieldEq[i]  = (almReg[i][FIELD_W-1:0] & FMASK) == curField[i];
    assign maskBits[i] = almReg[i][MASK_BIT];
  end

  assign rate      = decodeRate(maskBits);
  assign needField = rateNeeds(rate);
  assign matchHit  = secTick & (&(fieldEq | ~needField));

  // frequency-test divider: half period of HALF enables
  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      ftWave <= 1'b1;
    end else if (!strobes.divRun) begin
      divCnt <= '0;
      ftWave <= 1'b1;
    end else if (tick32k) begin
      if (divCnt == CNT_LAST) begin
        divCnt <= '0;
        ftWave <= ~ftWave;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  AST_EVERY_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && maskBits == 4'b1111) |-> matchHit);  // R1
  AST_NO_TICK_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |-> !matchHit);  // R6
  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.divRun && !tick32k) |=> $stable(ftWave));  // R11
  AST_WAVE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.divRun |=> ftWave);  // R11

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        cfgData,
  input  logic              flagsAcc,
  input  logic              powerFail,
  input  logic              wdSteer,
  input  logic              wdZero,
  input  logic              matchHit,
  input  logic              ftWave,
  output ctrlStrobes_t      strobes,
  output logic              alarmFlag,
  output logic              pinDriveLow
);

  logic aeBit, abeBit, ftBit;
  logic irqLatch;
  logic prevAcc, prevPf;
  logic wrOk, accEnd, pfFall;
  logic ftActive, alarmDrive;

  assign wrOk   = wrEn & ~powerFail;
  assign accEnd = prevAcc & ~flagsAcc;
  assign pfFall = prevPf & ~powerFail;

  for (genvar i = 0; i < NUM_ALM; i++) begin : gWr
    assign strobes.almWr[i] = wrOk && (wrAddr == ADDR_W'(i));
  end

  assign ftActive       = ftBit & ~aeBit & (wdSteer | wdZero);
  assign strobes.divRun = ftActive;

  // enables: cleared on the power-up transition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aeBit  <= 1'b0;
      abeBit <= 1'b0;
      ftBit  <= 1'b0;
    end else if (pfFall) begin
      aeBit  <= 1'b0;
      abeBit <= 1'b0;
      ftBit  <= 1'b0;
    end else if (wrOk && wrAddr == ADDR_CFG) begin
      aeBit  <= cfgData[CFG_AE - CFG_FT];
      abeBit <= cfgData[CFG_ABE - CFG_FT];
      ftBit  <= cfgData[0];
    end
  end

  // flag, interrupt latch and edge trackers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      irqLatch  <= 1'b0;
      prevAcc   <= 1'b0;
      prevPf    <= 1'b0;
    end else begin
      prevAcc <= flagsAcc;
      prevPf  <= powerFail;
      if (matchHit)    alarmFlag <= 1'b1;
      else if (accEnd) alarmFlag <= 1'b0;
      if (matchHit)      irqLatch <= 1'b1;
      else if (flagsAcc) irqLatch <= 1'b0;
    end
  end

  assign alarmDrive  = irqLatch & aeBit & (~powerFail | abeBit);
  assign pinDriveLow = alarmDrive | (ftActive & ~ftWave);

  AST_AF_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> alarmFlag);  // R6
  AST_AF_HOLD_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (flagsAcc && alarmFlag) |=> alarmFlag);  // R8
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (flagsAcc && !matchHit) |=> !irqLatch);  // R8
  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (powerFail && !abeBit && !ftActive) |-> !pinDriveLow);  // R9
  AST_PWRUP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerFail) |=> (!aeBit && !abeBit && !ftBit));  // R10
  AST_AE_GATES_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (!aeBit && !ftActive) |-> !pinDriveLow);  // R7

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int DIV_RATIO = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick32k,
  input  logic        secTick,
  input  logic [6:0]  curSec,
  input  logic [6:0]  curMin,
  input  logic [5:0]  curHour,
  input  logic [5:0]  curDate,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        flagsAcc,
  input  logic        powerFail,
  input  logic        wdSteer,
  input  logic        wdZero,
  output logic        alarmFlag,
  output logic        pinDriveLow,
  output logic        pinLevel
);

  ctrlStrobes_t strobes;
  logic         matchHit;
  logic         ftWave;

  rtc_alarm_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .cfgData    (wrData[CFG_AE:CFG_FT]),
    .flagsAcc   (flagsAcc),
    .powerFail  (powerFail),
    .wdSteer    (wdSteer),
    .wdZero     (wdZero),
    .matchHit   (matchHit),
    .ftWave     (ftWave),
    .strobes    (strobes),
    .alarmFlag  (alarmFlag),
    .pinDriveLow(pinDriveLow)
  );

  rtc_alarm_dp #(.DIV_RATIO(DIV_RATIO)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .secTick (secTick),
    .tick32k (tick32k),
    .curSec  (curSec),
    .curMin  (curMin),
    .curHour (curHour),
    .curDate (curDate),
    .matchHit(matchHit),
    .ftWave  (ftWave)
  );

  // open-drain pin: pulled high unless driven
  assign pinLevel = ~pinDriveLow;

  AST_PIN_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    pinLevel != pinDriveLow);  // R12

endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick32k = 1'b0, secTick = 1'b0;
  logic [6:0] curSec = '0, curMin = '0;
  logic [5:0] curHour = '0, curDate = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       flagsAcc = 1'b0, powerFail = 1'b0, wdSteer = 1'b0, wdZero = 1'b0;
  logic       alarmFlag, pinDriveLow, pinLevel;

  int testsRun = 0;
  int testsFailed = 0;
  bit tickOn = 1'b0;
  int tickPhase = 0;
  int toggleCount = 0;

  always #2 clk = ~clk;

  rtc_alarm_irq dut (.*);

  // ---------------- reference model ----------------
  bit [7:0] mAlm [4];
  bit mAe, mAbe, mFt, mAf, mIrq, mWave, mPrevAcc, mPrevPf;
  int mCnt;

  function automatic bit refMatch();
    bit [3:0] m;
    bit eS, eM, eH, eD;
    m  = {mAlm[3][7], mAlm[2][7], mAlm[1][7], mAlm[0][7]};
    eS = (mAlm[0] & 8'h7F) == {1'b0, curSec};
    eM = (mAlm[1] & 8'h7F) == {1'b0, curMin};
    eH = (mAlm[2] & 8'h3F) == {2'b0, curHour};
    eD = (mAlm[3] & 8'h3F) == {2'b0, curDate};
    case (m)
      4'b1110: return eS;
      4'b1100: return eS && eM;
      4'b1000: return eS && eM && eH;
      4'b0000: return eS && eM && eH && eD;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit refDrive();
    bit ftOn;
    ftOn = mFt && !mAe && (wdSteer || wdZero);
    return (mIrq && mAe && (!powerFail || mAbe)) || (ftOn && !mWave);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mAlm[i]) mAlm[i] = 8'h00;
      mAe = 0; mAbe = 0; mFt = 0; mAf = 0; mIrq = 0;
      mWave = 1; mCnt = 0; mPrevAcc = 0; mPrevPf = 0;
    end else begin
      bit hit, ftOn;
      hit  = secTick && refMatch();
      ftOn = mFt && !mAe && (wdSteer || wdZero);
      if (hit) mAf = 1; else if (mPrevAcc && !flagsAcc) mAf = 0;
      if (hit) mIrq = 1; else if (flagsAcc) mIrq = 0;
      if (!ftOn) begin
        mCnt = 0; mWave = 1;
      end else if (tick32k) begin
        if (mCnt == 31) begin mCnt = 0; mWave = !mWave; end
        else mCnt++;
      end
      if (mPrevPf && !powerFail) begin
        mAe = 0; mAbe = 0; mFt = 0;
      end else if (wrEn && !powerFail) begin
        if (wrAddr < 3'd4) mAlm[wrAddr] = wrData;
        else if (wrAddr == 3'd4) begin
          mAe = wrData[7]; mAbe = wrData[6]; mFt = wrData[5];
        end
      end
      mPrevAcc = flagsAcc;
      mPrevPf  = powerFail;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  bit cmpOn = 1'b0;
  logic prevPin = 1'b1;
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R6 alarmFlag vs model", alarmFlag, mAf);
      chk("R7 pinDriveLow vs model", pinDriveLow, refDrive());
      chk("R12 pinLevel inverse", pinLevel, !pinDriveLow);
      if (pinLevel !== prevPin) toggleCount++;
    end
    prevPin = pinLevel;
  end

  // 32 kHz enable: every other clock while on
  always @(posedge clk) begin
    #1;
    tickPhase++;
    tick32k = tickOn && (tickPhase % 2 == 0);
  end

  // ---------------- stimulus tasks ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic secPulse(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d);
    @(posedge clk); #1;
    curSec = s; curMin = m; curHour = h; curDate = d;
    secTick = 1;
    @(posedge clk); #1;
    secTick = 0;
    cyc(1);
  endtask

  task automatic flagAccess();
    @(posedge clk); #1;
    flagsAcc = 1;
    cyc(3);
    flagsAcc = 0;
    cyc(2);
  endtask

  task automatic setAlarms(input logic [7:0] a0, input logic [7:0] a1,
                           input logic [7:0] a2, input logic [7:0] a3);
    wrReg(3'd0, a0); wrReg(3'd1, a1); wrReg(3'd2, a2); wrReg(3'd3, a3);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    cyc(4);
    rstN = 1;
    cyc(1);
    cmpOn = 1;
    chk("R12 reset alarmFlag", alarmFlag, 1'b0);
    chk("R12 reset pinLevel", pinLevel, 1'b1);

    // R1: all masks set, alarm enabled
    wrReg(3'd4, 8'h80);
    setAlarms(8'h80, 8'h80, 8'h80, 8'h80);
    secPulse(7'h05, 7'h10, 6'h08, 6'h01);
    chk("R1 every-second flag", alarmFlag, 1'b1);
    chk("R7 pin driven", pinDriveLow, 1'b1);
    @(posedge clk); #1; flagsAcc = 1;
    cyc(1);
    chk("R8 irq released during access", pinDriveLow, 1'b0);
    chk("R8 flag held during access", alarmFlag, 1'b1);
    flagsAcc = 0;
    cyc(1);
    chk("R8 flag clears after access", alarmFlag, 1'b0);
    cyc(1);

    // R1: unlisted combination 1010
    setAlarms(8'h00, 8'h80, 8'h00, 8'h80);
    secPulse(7'h59, 7'h33, 6'h22, 6'h11);
    chk("R1 unlisted mask acts every second", alarmFlag, 1'b1);
    flagAccess();

    // R2: seconds only
    setAlarms(8'h30, 8'h80, 8'h80, 8'h80);
    secPulse(7'h29, 7'h00, 6'h00, 6'h01);
    chk("R2 seconds mismatch", alarmFlag, 1'b0);
    secPulse(7'h30, 7'h17, 6'h05, 6'h09);
    chk("R2 seconds match", alarmFlag, 1'b1);
    flagAccess();

    // R3: minutes and seconds
    setAlarms(8'h15, 8'h42, 8'h80, 8'h80);
    secPulse(7'h15, 7'h41, 6'h00, 6'h01);
    chk("R3 minute mismatch", alarmFlag, 1'b0);
    secPulse(7'h15, 7'h42, 6'h07, 6'h02);
    chk("R3 minute match", alarmFlag, 1'b1);
    flagAccess();

    // R4: hours, minutes, seconds
    setAlarms(8'h15, 8'h42, 8'h13, 8'h80);
    secPulse(7'h15, 7'h42, 6'h12, 6'h01);
    chk("R4 hour mismatch", alarmFlag, 1'b0);
    secPulse(7'h15, 7'h42, 6'h13, 6'h05);
    chk("R4 hour match", alarmFlag, 1'b1);
    flagAccess();

    // R5: full date match; hour alarm bit 6 set must be ignored
    setAlarms(8'h15, 8'h42, 8'h53, 8'h21);
    secPulse(7'h15, 7'h42, 6'h13, 6'h20);
    chk("R5 date mismatch", alarmFlag, 1'b0);
    secPulse(7'h15, 7'h42, 6'h13, 6'h21);
    chk("R5 date match", alarmFlag, 1'b1);
    flagAccess();

    // R6: matching time held without pulses must not retrigger
    cyc(12);
    chk("R6 no retrigger without secTick", alarmFlag, 1'b0);

    // R7: AE off, flag sets, pin stays released
    wrReg(3'd4, 8'h00);
    setAlarms(8'h80, 8'h80, 8'h80, 8'h80);
    secPulse(7'h01, 7'h01, 6'h01, 6'h01);
    chk("R7 flag with AE off", alarmFlag, 1'b1);
    chk("R7 pin released with AE off", pinDriveLow, 1'b0);
    wrReg(3'd4, 8'h80);
    cyc(1);
    chk("R7 latched irq drives after AE on", pinDriveLow, 1'b1);
    flagAccess();

    // R9: backup mode without backup enable
    @(posedge clk); #1; powerFail = 1;
    secPulse(7'h02, 7'h01, 6'h01, 6'h01);
    chk("R9 backup without ABE pin released", pinDriveLow, 1'b0);
    chk("R9 backup flag set", alarmFlag, 1'b1);
    wrReg(3'd4, 8'hC0);
    flagAccess();
    secPulse(7'h03, 7'h01, 6'h01, 6'h01);
    chk("R9 write ignored in backup", pinDriveLow, 1'b0);
    flagAccess();
    @(posedge clk); #1; powerFail = 0;
    cyc(2);
    // R10: AE was never written during backup, but power-up cleared it anyway
    wrReg(3'd4, 8'hC0);
    @(posedge clk); #1; powerFail = 1;
    secPulse(7'h04, 7'h01, 6'h01, 6'h01);
    chk("R9 backup with ABE drives pin", pinDriveLow, 1'b1);
    flagAccess();
    // R10: match in the power-up cycle
    @(posedge clk); #1;
    powerFail = 0; secTick = 1;
    @(posedge clk); #1; secTick = 0;
    chk("R10 power-up match sets flag", alarmFlag, 1'b1);
    chk("R10 enables cleared, pin released", pinDriveLow, 1'b0);
    flagAccess();

    // R11: frequency test with steering bit
    wdSteer = 1;
    tickOn = 1;
    wrReg(3'd4, 8'h20);
    toggleCount = 0;
    cyc(640);
    testsRun++;
    if (toggleCount < 9 || toggleCount > 10) begin
      testsFailed++;
      $display("FAIL R11 steer toggles: got %0d expected 9 or 10", toggleCount);
    end
    wdSteer = 0; wdZero = 0;
    cyc(2);
    toggleCount = 0;
    cyc(200);
    chk("R11 no wave without steer or zero", pinLevel, 1'b1);
    testsRun++;
    if (toggleCount != 0) begin
      testsFailed++;
      $display("FAIL R11 idle toggles: got %0d expected 0", toggleCount);
    end
    wdZero = 1;
    toggleCount = 0;
    cyc(300);
    testsRun++;
    if (toggleCount < 3) begin
      testsFailed++;
      $display("FAIL R11 zero-path toggles: got %0d expected at least 3", toggleCount);
    end
    wrReg(3'd4, 8'hA0);
    cyc(2);
    toggleCount = 0;
    cyc(200);
    chk("R11 AE blocks wave", pinDriveLow, 1'b0);
    // R10: power-up clears FT
    wrReg(3'd4, 8'h20);
    @(posedge clk); #1; powerFail = 1;
    cyc(3);
    powerFail = 0;
    cyc(2);
    toggleCount = 0;
    cyc(200);
    chk("R10 FT cleared by power-up", pinLevel, 1'b1);
    testsRun++;
    if (toggleCount != 0) begin
      testsFailed++;
      $display("FAIL R10 toggles after power-up: got %0d expected 0", toggleCount);
    end

    cmpOn = 0;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule